// File: doc/BRIEF.md
# Sub-Block Access Firewall

This block is a filter on a register bus. It stands in front of four peripheral windows: an entropy source, a memory port, a DMA engine and a miscellaneous-control block. Each window is one 256-byte page of the local address space. A small control page holds an 8-bit policy word. For each window, the policy word has one bit that refuses reads and another bit that refuses writes. A 2-bit security-level input decides how writes to the policy word are applied. At the lower levels a write can only add restrictions. At the top level a write can also remove them.

Each request arrives on a single-cycle request port. The firewall passes an allowed request to the downstream bus in the same cycle and returns the downstream read data through the same path. A refused request never reaches the downstream bus. A refused read returns zero. One clock after any refused request, the block raises a violation flag for one cycle. Requests to addresses outside the four windows and the control page pass through untouched.

Top module: `sec_fw`

## Requirements
- R1: After reset the policy word is 0x00, so every access is allowed and the violation flag is low.
- R2: Any address in page 0x4 (0x400–0x4FF) reaches the policy word. A read returns it in data bits 7:0 with the upper bits zero. A write updates it. Neither is forwarded downstream.
- R3: Policy bit 0 refuses reads of page 0x5 (entropy source). Bit 1 refuses reads of page 0x6 (memory port). Bit 2 refuses reads of page 0x7 (DMA). Bit 3 refuses reads of page 0x8 (misc control). A refused read returns zero and is not forwarded.
- R4: Policy bits 4, 5, 6 and 7 refuse writes to pages 0x5, 0x6, 0x7 and 0x8, in that order. A refused write is not forwarded and has no effect downstream.
- R5: Each refused request sets the violation flag high in the cycle after the request, for one cycle. An allowed request leaves the flag low.
- R6: When the level input is 0 (non-secure), 1 (light-secure) or 3 (treated as non-secure), a policy write ORs the written bits into the policy word. At these levels no bit can be cleared.
- R7: When the level input is 2 (heavy-secure), a policy write replaces the policy word. This is the only way to clear a bit.
- R8: Requests to pages other than 0x4 to 0x8, including addresses above the low 4 KiB, are forwarded unchanged. Their read data comes from downstream.
- R9: Reads and writes are gated separately. A window whose read bit is set still accepts writes, and a window whose write bit is set still returns read data.
- R10: An allowed access to a window is forwarded in the same cycle with the same address, direction and write data. Its read data is the downstream data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_mode | input | 2 | Security level: 0 non-secure, 1 light, 2 heavy, 3 as non-secure |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data for the current request |
| dn_valid | output | 1 | Forwarded request strobe |
| dn_write | output | 1 | Forwarded direction |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_rdata | input | DATA_W | Downstream read data |
| violation | output | 1 | One-cycle flag after a refused request |

## Verification
The bench builds the block with ADDR_W = 16 rather than the default 12, with DATA_W = 32 and 256-byte pages. The wider address lets it show that an address such as 0x1500 has the same low bits as a window but is not decoded as one and passes through. The 32-bit data width lets it confirm that a policy read leaves bits 31:8 at zero. The downstream stub returns data derived from the address, so the bench can tell forwarded read data apart from a refused read's zero.

// File: rtl/secfw_pkg.sv
package secfw_pkg;

  typedef enum logic [1:0] {
    LVL_NONSEC = 2'd0,
    LVL_LIGHT  = 2'd1,
    LVL_HEAVY  = 2'd2,
    LVL_RSVD   = 2'd3
  } sec_level_e;

  // Only the heavy level may remove restrictions; the reserved code
  // behaves like the non-secure level.
  function automatic logic level_is_heavy(input logic [1:0] lvl);
    return sec_level_e'(lvl) == LVL_HEAVY;
  endfunction

endpackage

// File: rtl/secfw_decode.sv
module secfw_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned PAGE_LSB = 8,
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned CTL_PAGE = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               ctl_hit,
  output logic [NUM_WIN-1:0] win_hit
);

  localparam int unsigned PAGE_W = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0] page;
  logic [PAGE_LSB-1:0] offs_unused;

  assign page        = addr[ADDR_W-1:PAGE_LSB];
  assign offs_unused = addr[PAGE_LSB-1:0];
  assign ctl_hit     = (page == PAGE_W'(CTL_PAGE));

  // Filtered windows follow the control page, one page each.
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g] = (page == PAGE_W'(CTL_PAGE + 1 + g));
  end

  logic unused_ok;
  assign unused_ok = ^offs_unused;

endmodule

// File: rtl/secfw_ctlreg.sv
module secfw_ctlreg #(
  parameter int unsigned NUM_WIN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 heavy,
  input  logic                 wr_en,
  input  logic [2*NUM_WIN-1:0] wr_val,
  output logic [2*NUM_WIN-1:0] ctl_q
);

  localparam int unsigned CTL_W = 2 * NUM_WIN;

  logic [CTL_W-1:0] ctl_d;

  // Next state: replace when heavy, otherwise accumulate only.
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      if (heavy) ctl_d = wr_val;
      else       ctl_d = ctl_q | wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

endmodule

// File: rtl/secfw_gate.sv
module secfw_gate #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 ctl_hit,
  input  logic [NUM_WIN-1:0]   win_hit,
  input  logic [2*NUM_WIN-1:0] ctl_q,
  input  logic [DATA_W-1:0]    dn_rdata,
  output logic                 fwd_en,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 violation
);

  logic [NUM_WIN-1:0] rd_off;
  logic [NUM_WIN-1:0] wr_off;
  logic [NUM_WIN-1:0] refuse_vec;
  logic               refused;
  logic               viol_d;

  assign rd_off = ctl_q[NUM_WIN-1:0];
  assign wr_off = ctl_q[2*NUM_WIN-1:NUM_WIN];

  always_comb begin
    refuse_vec = win_hit & (req_write ? wr_off : rd_off);
    refused    = |refuse_vec;
    fwd_en     = req_valid && !ctl_hit && !refused;
    if (ctl_hit)      rsp_rdata = DATA_W'(ctl_q);
    else if (refused) rsp_rdata = '0;
    else              rsp_rdata = dn_rdata;
    viol_d     = req_valid && refused;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) violation <= 1'b0;
    else        violation <= viol_d;
  end

endmodule

// File: rtl/sec_fw.sv
module sec_fw #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PAGE_LSB = 8,
  parameter int unsigned NUM_WIN  = 4,
  parameter int unsigned CTL_PAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sec_mode,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              violation
);

  localparam int unsigned CTL_W = 2 * NUM_WIN;

  logic               ctl_hit;
  logic [NUM_WIN-1:0] win_hit;
  logic [CTL_W-1:0]   ctl_q;
  logic               ctl_wr;
  logic               heavy;

  assign heavy  = secfw_pkg::level_is_heavy(sec_mode);
  assign ctl_wr = req_valid && req_write && ctl_hit;

  secfw_decode #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .NUM_WIN(NUM_WIN), .CTL_PAGE(CTL_PAGE)
  ) u_dec (
    .addr(req_addr), .ctl_hit(ctl_hit), .win_hit(win_hit)
  );

  secfw_ctlreg #(.NUM_WIN(NUM_WIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .heavy(heavy), .wr_en(ctl_wr),
    .wr_val(req_wdata[CTL_W-1:0]), .ctl_q(ctl_q)
  );

  secfw_gate #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ctl_hit(ctl_hit), .win_hit(win_hit), .ctl_q(ctl_q), .dn_rdata(dn_rdata),
    .fwd_en(dn_valid), .rsp_rdata(rsp_rdata), .violation(violation)
  );

  assign dn_write = req_write;
  assign dn_addr  = req_addr;
  assign dn_wdata = req_wdata;

endmodule

// File: rtl/sec_fw_chk.sv
module sec_fw_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           sec_mode,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 ctl_hit,
  input logic [NUM_WIN-1:0]   win_hit,
  input logic [2*NUM_WIN-1:0] ctl_q,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic                 dn_valid,
  input logic                 violation
);

  AST_RD_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && |(win_hit & ctl_q[NUM_WIN-1:0]))
      |-> (rsp_rdata == '0 && !dn_valid)); // R3

  AST_WR_REFUSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && |(win_hit & ctl_q[2*NUM_WIN-1:NUM_WIN]))
      |-> !dn_valid); // R4

  AST_VIOL_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && |win_hit && !dn_valid) |=> violation); // R5

  AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> ($past(req_valid) && $past(|win_hit))); // R5

  AST_LOW_LEVEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_mode != 2'd2) |=> ((ctl_q & $past(ctl_q)) == $past(ctl_q))); // R6

  AST_OUTSIDE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ctl_hit && win_hit == '0) |-> dn_valid); // R8

  AST_CTL_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ctl_hit) |-> !dn_valid); // R2

endmodule

bind sec_fw sec_fw_chk #(.DATA_W(DATA_W), .NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_mode(sec_mode), .req_valid(req_valid),
  .req_write(req_write), .ctl_hit(ctl_hit), .win_hit(win_hit), .ctl_q(ctl_q),
  .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .violation(violation)
);

// File: tb/sec_fw_test.sv
`timescale 1ns/1ps
module sec_fw_test;

  localparam int unsigned AW = 16;
  localparam int unsigned DW = 32;

  logic          clk;
  logic          rst_n;
  logic [1:0]    sec_mode;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] rsp_rdata;
  logic          dn_valid;
  logic          dn_write;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [DW-1:0] dn_rdata;
  logic          violation;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  logic [AW-1:0] last_waddr;
  logic [DW-1:0] last_wdata;

  sec_fw #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .sec_mode(sec_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .violation(violation)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Downstream stub: read data tagged with the address; writes recorded.
  assign dn_rdata = 32'hC0DE_0000 | {16'h0, dn_addr};
  always @(posedge clk) begin
    if (dn_valid && dn_write) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= dn_addr;
      last_wdata <= dn_wdata;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access plus one idle cycle; returns combinational and flag results.
  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd, output logic fw,
                     output logic v1, output logic v2);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    rd = rsp_rdata; fw = dn_valid;
    @(posedge clk); #1;
    v1 = violation;
    req_valid = 1'b0; req_write = 1'b0;
    @(posedge clk); #1;
    v2 = violation;
  endtask

  task automatic ctl_is(input string tag, input logic [7:0] exp);
    logic [DW-1:0] rd; logic fw, v1, v2;
    acc(1'b0, 16'h0400, '0, rd, fw, v1, v2);
    chk(tag, rd, {24'h0, exp});
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; logic fw, v1, v2;
    chk("R1 violation after reset", {31'h0, violation}, 32'h0);
    acc(1'b0, 16'h04F0, '0, rd, fw, v1, v2);
    chk("R1 policy word reset", rd, 32'h0);
    chk("R2 policy read not forwarded", {31'h0, fw}, 32'h0);
    acc(1'b0, 16'h0500, '0, rd, fw, v1, v2);
    chk("R1 entropy read allowed", rd, 32'hC0DE_0500);
  endtask

  task automatic t_read_refuse();
    logic [DW-1:0] rd; logic fw, v1, v2; int n0;
    sec_mode = 2'd0;
    acc(1'b1, 16'h0400, 32'hFFFF_FF01, rd, fw, v1, v2);
    chk("R2 policy write not forwarded", {31'h0, fw}, 32'h0);
    ctl_is("R2 policy word upper bits zero", 8'h01);
    acc(1'b0, 16'h0520, '0, rd, fw, v1, v2);
    chk("R3 refused read data", rd, 32'h0);
    chk("R3 refused read not forwarded", {31'h0, fw}, 32'h0);
    chk("R5 violation pulse", {31'h0, v1}, 32'h1);
    chk("R5 violation one cycle", {31'h0, v2}, 32'h0);
    acc(1'b0, 16'h0630, '0, rd, fw, v1, v2);
    chk("R3 bit0 only covers entropy page", rd, 32'hC0DE_0630);
    chk("R5 no violation on allowed", {31'h0, v1}, 32'h0);
    acc(1'b1, 16'h0400, 32'h04, rd, fw, v1, v2);
    acc(1'b0, 16'h07FC, '0, rd, fw, v1, v2);
    chk("R3 bit2 refuses DMA read", rd, 32'h0);
    n0 = wr_cnt;
    acc(1'b1, 16'h0704, 32'h1234_5678, rd, fw, v1, v2);
    chk("R9 write to read-refused page forwarded", {31'h0, fw}, 32'h1);
    chk("R10 downstream got write", wr_cnt - n0, 1);
    chk("R10 forwarded write data", last_wdata, 32'h1234_5678);
    chk("R10 forwarded write addr", {16'h0, last_waddr}, 32'h0704);
  endtask

  task automatic t_accumulate();
    sec_mode = 2'd1;
    begin
      logic [DW-1:0] rd; logic fw, v1, v2;
      acc(1'b1, 16'h0400, 32'h00, rd, fw, v1, v2);
      ctl_is("R6 light level cannot clear", 8'h05);
      sec_mode = 2'd3;
      acc(1'b1, 16'h0400, 32'h80, rd, fw, v1, v2);
      ctl_is("R6 reserved level ORs", 8'h85);
    end
  endtask

  task automatic t_write_refuse();
    logic [DW-1:0] rd; logic fw, v1, v2; int n0;
    sec_mode = 2'd0;
    n0 = wr_cnt;
    acc(1'b1, 16'h0810, 32'hDEAD_BEEF, rd, fw, v1, v2);
    chk("R4 bit7 refuses misc write", {31'h0, fw}, 32'h0);
    chk("R4 nothing reached downstream", wr_cnt - n0, 0);
    chk("R5 violation on refused write", {31'h0, v1}, 32'h1);
    acc(1'b0, 16'h0810, '0, rd, fw, v1, v2);
    chk("R9 read of write-refused page", rd, 32'hC0DE_0810);
  endtask

  task automatic t_heavy();
    logic [DW-1:0] rd; logic fw, v1, v2;
    sec_mode = 2'd2;
    acc(1'b1, 16'h0400, 32'h20, rd, fw, v1, v2);
    ctl_is("R7 heavy level replaces", 8'h20);
    acc(1'b0, 16'h0700, '0, rd, fw, v1, v2);
    chk("R7 cleared bit reopens DMA read", rd, 32'hC0DE_0700);
    acc(1'b1, 16'h0600, 32'h1, rd, fw, v1, v2);
    chk("R4 bit5 refuses memory-port write", {31'h0, fw}, 32'h0);
    acc(1'b1, 16'h0500, 32'h1, rd, fw, v1, v2);
    chk("R4 bit5 leaves entropy write open", {31'h0, fw}, 32'h1);
  endtask

  task automatic t_outside();
    logic [DW-1:0] rd; logic fw, v1, v2;
    sec_mode = 2'd2;
    acc(1'b1, 16'h0400, 32'hFF, rd, fw, v1, v2);
    acc(1'b0, 16'h1500, '0, rd, fw, v1, v2);
    chk("R8 high alias passes", rd, 32'hC0DE_1500);
    chk("R8 no violation outside", {31'h0, v1}, 32'h0);
    acc(1'b1, 16'h0900, 32'h55, rd, fw, v1, v2);
    chk("R8 page 9 write forwarded", {31'h0, fw}, 32'h1);
    acc(1'b0, 16'h0000, '0, rd, fw, v1, v2);
    chk("R8 page 0 read passes", rd, 32'hC0DE_0000);
  endtask

  initial begin
    rst_n = 1'b0; sec_mode = 2'd0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_read_refuse();
    t_accumulate();
    t_write_refuse();
    t_heavy();
    t_outside();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule